// File: doc/BRIEF.md
# Scanline Interrupt Reload Counter

This block is an 8-bit down-counter that raises an interrupt after a programmed number of video-fetch events. The events are rising edges of one video-address line. The block samples that line against the system clock and turns each 0-to-1 transition into a single-cycle event. The CPU side programs the block through a write strobe, a 2-bit register select and an 8-bit data value. Through these writes it sets the reload value, asks for a reload, and turns the interrupt on, or turns it off and acknowledges it.

The counter never takes a new value straight from a write. On each event it either loads the stored reload value or decrements. It loads when the count is zero or when a reload was requested since the previous event. It decrements in every other case. The interrupt is decided only on an event, and it is set when that event leaves the count at zero while interrupts are on. An interrupt that is set stays set until the CPU turns interrupts off.

Top module: `scanline_irq_counter`

## Requirements
- R1: After reset the count output is 0 and the interrupt output is low. The reload value and the pending-reload flag are 0 and interrupts are off.
- R2: A write with select 0 stores the data as the reload value, and the count does not change until the next event.
- R3: On an event with a nonzero count and no pending reload, the count decreases by one.
- R4: On an event with a count of zero, the count loads the reload value.
- R5: A write with select 1 leaves the count as it is. The next event loads the reload value even when the count is nonzero, and that event clears the request, so the following event decrements.
- R6: When an event leaves the count at zero while interrupts are on, the interrupt output goes high one cycle later. It stays high over later events until a write with select 2.
- R7: A write with select 2 turns interrupts off and drops the interrupt output. A write with select 3 turns interrupts on and does not change the count or the reload value.
- R8: While interrupts are off, an event that reaches zero sets no interrupt, and a later select 3 write does not raise the interrupt by itself.
- R9: With a reload value of 0, every event loads 0 and raises the interrupt while interrupts are on.
- R10: An event happens only on a 0-to-1 change of the address line. The count changes SYNC_STAGES+1 clock edges after the line is first sampled high. Holding the line high or lowering it causes no further event.
- R11: When a write and an event fall in the same cycle, the event uses the state from before the write. A select 1 write in that cycle stays pending for the next event. A select 2 write in that cycle leaves the interrupt low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| wr_sel_i | input | 2 | Register select: 0 reload value, 1 reload request, 2 interrupt off/acknowledge, 3 interrupt on |
| wr_data_i | input | 8 | Write data, used by select 0 |
| vaddr_line_i | input | 1 | Video-address line whose rising edges clock the counter |
| irq_o | output | 1 | Interrupt pending, active high |
| count_o | output | 8 | Current counter value, for test |

## Verification
The counter is driven through full countdowns from a nonzero reload value. These show that a zero count reloads, that other counts decrement, and that the interrupt stays set across later events. A reload request made with a nonzero count is checked against a plain decrement, which shows whether the request is taken and then cleared. A reload value of zero shows that the interrupt fires on every event. Countdowns with interrupts off show that enable is the only gate on the interrupt. A long high level on the address line, and writes placed in the same cycle as an event, check the single-edge rule and the rule that an event uses the state from before the write.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;
  typedef enum logic [1:0] {
    SEL_RELOAD_VAL = 2'd0,
    SEL_RELOAD_REQ = 2'd1,
    SEL_IRQ_OFF    = 2'd2,
    SEL_IRQ_ON     = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic set_reload;
    logic req_reload;
    logic irq_off;
    logic irq_on;
  } wr_cmd_t;
endpackage

// File: rtl/sirq_wr_decode.sv
module sirq_wr_decode
  import scan_irq_pkg::*;
(
  input  logic       wr_en_i,
  input  logic [1:0] wr_sel_i,
  output wr_cmd_t    cmd_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel_i);

  always_comb begin
    cmd_o = '0;
    if (wr_en_i) begin
      unique case (sel)
        SEL_RELOAD_VAL: cmd_o.set_reload = 1'b1;
        SEL_RELOAD_REQ: cmd_o.req_reload = 1'b1;
        SEL_IRQ_OFF:    cmd_o.irq_off    = 1'b1;
        SEL_IRQ_ON:     cmd_o.irq_on     = 1'b1;
        default:        cmd_o            = '0;
      endcase
    end
  end
endmodule

// File: rtl/sirq_edge_detect.sv
module sirq_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= line_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  // a rising edge can never yield events on two adjacent cycles
  assert_single_event_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sirq_count_core.sv
module sirq_count_core
  import scan_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  wr_cmd_t          cmd_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_hit_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] reload_q, count_q, count_nxt;
  logic             pend_q, take_reload;

  assign take_reload = (count_q == '0) | pend_q;
  assign count_nxt   = take_reload ? reload_q : count_q - ONE;
  assign zero_hit_o  = evt_i & (count_nxt == '0);
  assign count_o     = count_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               reload_q <= '0;
    else if (cmd_i.set_reload) reload_q <= data_i;

  // a request made in the event cycle survives for the next event
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               pend_q <= 1'b0;
    else if (cmd_i.req_reload) pend_q <= 1'b1;
    else if (evt_i)            pend_q <= 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    count_q <= '0;
    else if (evt_i) count_q <= count_nxt;

  assert_hold_no_event_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> $stable(count_q));
  assert_decrement_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !pend_q && count_q != '0) |=> count_q == $past(count_q) - ONE);
  assert_zero_reloads_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && count_q == '0) |=> count_q == $past(reload_q));
  assert_request_reloads_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && pend_q) |=> count_q == $past(reload_q));
endmodule

// File: rtl/sirq_irq_ctrl.sv
module sirq_irq_ctrl
  import scan_irq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    zero_hit_i,
  input  wr_cmd_t cmd_i,
  output logic    irq_o
);
  logic en_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            en_q <= 1'b0;
    else if (cmd_i.irq_off) en_q <= 1'b0;
    else if (cmd_i.irq_on)  en_q <= 1'b1;

  // acknowledge wins over a hit in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                 irq_q <= 1'b0;
    else if (cmd_i.irq_off)      irq_q <= 1'b0;
    else if (zero_hit_i && en_q) irq_q <= 1'b1;

  assign irq_o = irq_q;

  assert_irq_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !cmd_i.irq_off) |=> irq_q);
  assert_off_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.irq_off |=> !irq_q);
  assert_no_set_when_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !$rose(irq_q));
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import scan_irq_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             vaddr_line_i,
  output logic             irq_o,
  output logic [CNT_W-1:0] count_o
);
  wr_cmd_t cmd;
  logic    evt, zero_hit;

  sirq_wr_decode u_dec (
    .wr_en_i (wr_en_i),
    .wr_sel_i(wr_sel_i),
    .cmd_o   (cmd)
  );

  sirq_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(vaddr_line_i),
    .rise_o(evt)
  );

  sirq_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .cmd_i     (cmd),
    .data_i    (wr_data_i),
    .count_o   (count_o),
    .zero_hit_o(zero_hit)
  );

  sirq_irq_ctrl u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .zero_hit_i(zero_hit),
    .cmd_i     (cmd),
    .irq_o     (irq_o)
  );
endmodule

// File: tb/tb_scanline_irq_counter.sv
module tb_scanline_irq_counter;
  localparam int S = 2;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic         vline = 1'b0;
  logic         irq;
  logic [W-1:0] count;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  scanline_irq_counter #(.CNT_W(W), .SYNC_STAGES(S)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .vaddr_line_i(vline), .irq_o(irq), .count_o(count)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_latch, m_nxt;
  bit m_pend, m_en, m_irq, m_ev, m_hit;
  bit hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_latch = 0; m_pend = 0; m_en = 0; m_irq = 0;
      hist = {};
      for (int i = 0; i <= S; i++) hist.push_back(1'b0);
    end else begin
      m_ev = hist[S-1] && !hist[S];
      if (m_ev) begin
        m_nxt = (m_cnt == 0 || m_pend) ? m_latch : (m_cnt - 1);
        m_hit = (m_nxt == 0) && m_en;
        m_cnt = m_nxt;
        m_pend = 0;
        if (m_hit) m_irq = 1;
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0: m_latch = int'(wr_data);
          2'd1: m_pend = 1;
          2'd2: begin m_en = 0; m_irq = 0; end
          default: m_en = 1;
        endcase
      end
      hist.push_front(vline);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(count) == m_cnt, "R3 model count", int'(count), m_cnt);
      check(irq == m_irq, "R6 model irq", int'(irq), int'(m_irq));
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    vline = 1'b1;
    repeat (S + 2) @(negedge clk);
    vline = 1'b0;
    repeat (S + 2) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run hung");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(count == 0, "R1 reset count", int'(count), 0);
    check(irq == 0, "R1 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    pulse();
    check(count == 0, "R1 reset reload value zero", int'(count), 0);
    check(irq == 0, "R1 reset irq disabled", int'(irq), 0);

    wr(2'd0, 8'd3);
    check(count == 0, "R2 latch write leaves count", int'(count), 0);
    wr(2'd3, 8'd0);
    pulse();
    check(count == 3, "R4 zero count reloads", int'(count), 3);
    check(irq == 0, "R6 no irq on nonzero", int'(irq), 0);
    pulse();
    check(count == 2, "R3 decrement", int'(count), 2);
    pulse();
    pulse();
    check(count == 0, "R3 reach zero", int'(count), 0);
    check(irq == 1, "R6 irq on zero", int'(irq), 1);
    pulse();
    check(count == 3, "R4 reload after zero", int'(count), 3);
    check(irq == 1, "R6 irq held", int'(irq), 1);
    wr(2'd2, 8'd0);
    check(irq == 0, "R7 off clears irq", int'(irq), 0);
    wr(2'd3, 8'd0);
    check(count == 3, "R7 on keeps count", int'(count), 3);
    check(irq == 0, "R7 on does not raise irq", int'(irq), 0);

    wr(2'd1, 8'd0);
    check(count == 3, "R5 request not immediate", int'(count), 3);
    pulse();
    check(count == 3, "R5 request reloads", int'(count), 3);
    pulse();
    check(count == 2, "R5 request consumed", int'(count), 2);

    wr(2'd2, 8'd0);
    pulse();
    pulse();
    check(count == 0, "R8 count zero while off", int'(count), 0);
    check(irq == 0, "R8 no irq while off", int'(irq), 0);
    wr(2'd3, 8'd0);
    check(irq == 0, "R8 enable does not raise", int'(irq), 0);

    wr(2'd0, 8'd0);
    pulse();
    check(count == 0, "R9 zero latch reload", int'(count), 0);
    check(irq == 1, "R9 irq with zero latch", int'(irq), 1);
    wr(2'd2, 8'd0);
    wr(2'd3, 8'd0);
    pulse();
    check(irq == 1, "R9 irq again with zero latch", int'(irq), 1);

    wr(2'd2, 8'd0);
    wr(2'd0, 8'd5);
    wr(2'd1, 8'd0);
    @(negedge clk);
    vline = 1'b1;
    repeat (S) @(negedge clk);
    check(count == 0, "R10 latency before change", int'(count), 0);
    @(negedge clk);
    check(count == 5, "R10 change after sync", int'(count), 5);
    repeat (8) @(negedge clk);
    check(count == 5, "R10 held high no event", int'(count), 5);
    vline = 1'b0;
    repeat (S + 3) @(negedge clk);
    check(count == 5, "R10 falling no event", int'(count), 5);

    @(negedge clk);
    vline = 1'b1;
    repeat (S) @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'd0;
    @(negedge clk);
    wr_en = 1'b0;
    check(count == 4, "R11 event uses old request", int'(count), 4);
    vline = 1'b0;
    repeat (S + 2) @(negedge clk);
    pulse();
    check(count == 5, "R11 same-cycle request kept", int'(count), 5);

    wr(2'd3, 8'd0);
    wr(2'd0, 8'd1);
    wr(2'd1, 8'd0);
    pulse();
    check(count == 1, "R11 setup", int'(count), 1);
    @(negedge clk);
    vline = 1'b1;
    repeat (S) @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd2;
    @(negedge clk);
    wr_en = 1'b0;
    check(count == 0, "R11 event in off cycle", int'(count), 0);
    check(irq == 0, "R11 off wins over hit", int'(irq), 0);
    vline = 1'b0;
    repeat (S + 2) @(negedge clk);

    finish_run();
  end
endmodule